// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Transceiver

This block carries bytes over one shared wire that rests low. Each bit opens with a driven rising edge, and the bit value lies in how long the wire then stays high: a short high phase means 0 and a long one means 1. No other wire carries a clock or control. Every message opens with a synchronization bit, a logic 1 sent at the sender's chosen bit period. The receiver measures the time from that bit's rising edge to the next rising edge and uses the result as the bit time for the rest of the message. The rate therefore follows each message, across the range from 2 kbit/s to 2 Mbit/s.

On the transmit side, bytes enter through a valid/ready stream. A flag marks the final byte of a message. The block sends the synchronization bit, then the data bytes MSB first, then a CRC-8 check byte, and keeps the wire quiet for three bit periods before the next message can start. The wire is driven open-drain: `line_oe` pulls it high, and between high phases the wire is released. On the receive side, decoded bytes come out as one-cycle pulses, and the received check byte is included. A message-end pulse reports whether the CRC matched, and a separate pulse reports framing faults. While the block is transmitting, its own receiver is held idle.

Top module: `owb_xcvr`

## Requirements
- R1: After reset, `line_oe` is 0, `tx_ready` is 1, and `rx_valid`, `rx_end` and `rx_frame_err` are 0.
- R2: A transmitted message opens with a logic-1 synchronization bit. The period P of that bit, and of every later bit in the message, is the value of `tx_period` (in clock cycles) one cycle after the first byte is accepted. A later change of `tx_period` has no effect until the next message.
- R3: At period P (P >= 8), every bit starts with `line_oe` high. A 0 holds it high for floor(P/4) cycles and a 1 for P - floor(P/4) cycles. `line_oe` stays low for the rest of the bit, and it is high only while a message is being sent.
- R4: Bytes are sent MSB first. After the byte flagged by `tx_last`, a CRC byte follows, and then the wire stays released for 3P cycles.
- R5: The CRC uses polynomial x^8+x^2+x+1 (0x07) with initial value 0x00. It is computed MSB first over the data bytes of the message, with no final inversion.
- R6: The receiver takes P from the rise-to-rise interval of the synchronization bit. It samples the wire P/2 cycles (rounded down) after each rise, where high means 1. Every 8 bits it presents a byte on `rx_data` with a one-cycle `rx_valid`, and the received CRC byte is one of these bytes.
- R7: If no rise follows within 2P cycles of the last rise, and the receiver is on a byte boundary, it pulses `rx_end`. In the same cycle `rx_crc_ok` is 1 exactly when the CRC over all received bytes, check byte included, is zero. `rx_crc_ok` is 0 whenever `rx_end` is 0.
- R8: A missing rise for 2P cycles in the middle of a byte, or a high phase that lasts P cycles, pulses `rx_frame_err` instead of `rx_end` and returns the receiver to idle.
- R9: While the block transmits, including the quiet gap, its own receiver produces no `rx_valid`, `rx_end` or `rx_frame_err`.
- R10: The transmit side holds one byte. `tx_ready` drops in the cycle after a byte is accepted and stays low until that byte is loaded for sending.
- R11: Consecutive messages at different bit periods are each decoded correctly, because P is measured again for every message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_period | input | CNT_W | Bit period in clock cycles for the next message |
| tx_data | input | 8 | Byte to send |
| tx_last | input | 1 | Marks the final data byte of a message |
| tx_valid | input | 1 | `tx_data` and `tx_last` are valid |
| tx_ready | output | 1 | The holding register can take a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| rx_end | output | 1 | One-cycle pulse: message ended cleanly |
| rx_crc_ok | output | 1 | CRC result, valid with `rx_end` |
| rx_frame_err | output | 1 | One-cycle pulse: framing fault detected |
| line_oe | output | 1 | Pull the wire high (open-drain enable) |
| line_in | input | 1 | Level of the wire |

## Verification
Two instances share one wired-OR line, and a table of messages at periods 12, 16, 40 and 64 cycles runs between them. The data bytes include all-zero, all-one, single-bit and alternating patterns. The patterns tell 0 apart from 1 bit-by-bit, show MSB-first order, and prove that the rate is measured again when the period changes between messages. The transmit waveform is measured at the wire to confirm the synchronization period and both high-phase widths. The bench also drives hand-made pulse trains into the receiver: a correct and a corrupted check byte separate a CRC pass from a CRC fail, and a silence in mid-byte and an over-long high phase each show a framing fault instead of a clean end.

// File: rtl/owb_pkg.sv
package owb_pkg;

    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC,
        TX_DATA,
        TX_CRC,
        TX_GAP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SYNC,
        RX_BIT
    } rx_state_e;

    // Fold one byte into the running check value, most significant bit first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] data);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ data[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/owb_tx.sv
module owb_tx
    import owb_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [7:0]       data_i,
    input  logic             last_i,
    input  logic             valid_i,
    output logic             ready_o,
    output logic             oe_o,
    output logic             busy_o
);
    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [7:0]       sh;
        logic [2:0]       bidx;
        logic             last;
        logic [7:0]       crc;
        logic [7:0]       hold;
        logic             hold_last;
        logic             hold_vld;
        logic [1:0]       gapn;
    } tx_regs_t;

    tx_regs_t         d, q;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] hi_len;
    logic             bit_val;
    logic             bit_end;
    logic             sending;

    always_comb begin
        quarter = q.per >> 2;
        bit_val = (q.st == TX_SYNC) ? 1'b1 : q.sh[7];
        hi_len  = bit_val ? (q.per - quarter) : quarter;
        bit_end = (q.cnt == q.per - CNT_W'(1));
        sending = (q.st == TX_SYNC) || (q.st == TX_DATA) || (q.st == TX_CRC);

        d = q;
        if (valid_i && !q.hold_vld) begin
            d.hold      = data_i;
            d.hold_last = last_i;
            d.hold_vld  = 1'b1;
        end

        unique case (q.st)
            TX_IDLE: begin
                if (q.hold_vld) begin
                    d.per = period_i;
                    d.crc = 8'h00;
                    d.cnt = '0;
                    d.st  = TX_SYNC;
                end
            end
            TX_SYNC, TX_DATA: begin
                if (!bit_end) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end else if (q.st == TX_DATA && q.bidx != 3'd7) begin
                    d.sh   = {q.sh[6:0], 1'b0};
                    d.bidx = q.bidx + 3'd1;
                    d.cnt  = '0;
                end else if (q.st == TX_DATA && q.last) begin
                    d.sh   = q.crc;
                    d.bidx = 3'd0;
                    d.cnt  = '0;
                    d.st   = TX_CRC;
                end else if (q.hold_vld) begin
                    d.sh       = q.hold;
                    d.last     = q.hold_last;
                    d.hold_vld = 1'b0;
                    d.crc      = crc8_byte(q.crc, q.hold);
                    d.bidx     = 3'd0;
                    d.cnt      = '0;
                    d.st       = TX_DATA;
                end
                // otherwise wait released at the end of the bit for a byte
            end
            TX_CRC: begin
                if (!bit_end) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end else if (q.bidx == 3'd7) begin
                    d.cnt  = '0;
                    d.gapn = 2'd0;
                    d.st   = TX_GAP;
                end else begin
                    d.sh   = {q.sh[6:0], 1'b0};
                    d.bidx = q.bidx + 3'd1;
                    d.cnt  = '0;
                end
            end
            TX_GAP: begin
                if (!bit_end) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end else begin
                    d.cnt = '0;
                    if (q.gapn == 2'd2) d.st = TX_IDLE;
                    else                d.gapn = q.gapn + 2'd1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o = !q.hold_vld;
    assign oe_o    = sending && (q.cnt < hi_len);
    assign busy_o  = (q.st != TX_IDLE);
endmodule

// File: rtl/owb_rx.sv
module owb_rx
    import owb_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       lvl_i,
    input  logic       rise_i,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       end_o,
    output logic       ok_o,
    output logic       err_o
);
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        rx_state_e        st;
        logic [CW-1:0]    cnt;
        logic [CNT_W-1:0] per;
        logic [6:0]       sh;
        logic [2:0]       bcnt;
        logic [7:0]       crc;
        logic [7:0]       data;
        logic             valid;
        logic             fin;
        logic             ok;
        logic             err;
    } rx_regs_t;

    rx_regs_t      d, q;
    logic [CW-1:0] per_w;
    logic [CW-1:0] half;
    logic [CW-1:0] twice;
    logic [7:0]    newbyte;

    always_comb begin
        per_w   = {1'b0, q.per};
        half    = per_w >> 1;
        twice   = {q.per, 1'b0};
        newbyte = {q.sh, lvl_i};

        d       = q;
        d.valid = 1'b0;
        d.fin   = 1'b0;
        d.ok    = 1'b0;
        d.err   = 1'b0;

        if (!en_i) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                RX_IDLE: begin
                    if (rise_i) begin
                        d.st   = RX_SYNC;
                        d.cnt  = CW'(1);
                        d.crc  = 8'h00;
                        d.bcnt = 3'd0;
                    end
                end
                RX_SYNC: begin
                    if (rise_i) begin
                        d.per = q.cnt[CNT_W-1:0];
                        d.cnt = CW'(1);
                        d.st  = RX_BIT;
                    end else if (q.cnt[CNT_W-1:0] == '1) begin
                        d.err = 1'b1;
                        d.st  = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                RX_BIT: begin
                    if (rise_i) begin
                        d.cnt = CW'(1);
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                        if (q.cnt == half) begin
                            d.sh   = newbyte[6:0];
                            d.bcnt = q.bcnt + 3'd1;
                            if (q.bcnt == 3'd7) begin
                                d.data  = newbyte;
                                d.valid = 1'b1;
                                d.crc   = crc8_byte(q.crc, newbyte);
                            end
                        end
                        if (lvl_i && q.cnt >= per_w) begin
                            d.err = 1'b1;
                            d.st  = RX_IDLE;
                        end else if (q.cnt >= twice) begin
                            if (q.bcnt == 3'd0) begin
                                d.fin = 1'b1;
                                d.ok  = (q.crc == 8'h00);
                            end else begin
                                d.err = 1'b1;
                            end
                            d.st = RX_IDLE;
                        end
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign end_o   = q.fin;
    assign ok_o    = q.ok;
    assign err_o   = q.err;
endmodule

// File: rtl/owb_xcvr.sv
module owb_xcvr #(
    parameter int CNT_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_period,
    input  logic [7:0]       tx_data,
    input  logic             tx_last,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_end,
    output logic             rx_crc_ok,
    output logic             rx_frame_err,
    output logic             line_oe,
    input  logic             line_in
);
    logic tx_busy;
    logic line_lvl;
    logic line_rise;

    owb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .lvl  (line_lvl),
        .rise (line_rise)
    );

    owb_tx #(.CNT_W(CNT_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .period_i(tx_period),
        .data_i  (tx_data),
        .last_i  (tx_last),
        .valid_i (tx_valid),
        .ready_o (tx_ready),
        .oe_o    (line_oe),
        .busy_o  (tx_busy)
    );

    owb_rx #(.CNT_W(CNT_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (!tx_busy),
        .lvl_i  (line_lvl),
        .rise_i (line_rise),
        .data_o (rx_data),
        .valid_o(rx_valid),
        .end_o  (rx_end),
        .ok_o   (rx_crc_ok),
        .err_o  (rx_frame_err)
    );
endmodule

// File: rtl/owb_xcvr_chk.sv
module owb_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_busy,
    input logic line_oe,
    input logic rx_valid,
    input logic rx_end,
    input logic rx_crc_ok,
    input logic rx_frame_err
);
    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_oe_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> tx_busy);

    assert_rx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> !(rx_valid || rx_end || rx_frame_err));

    assert_ok_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_ok |-> rx_end);

    assert_end_excl_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_end && rx_frame_err));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind owb_xcvr owb_xcvr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_busy     (tx_busy),
    .line_oe     (line_oe),
    .rx_valid    (rx_valid),
    .rx_end      (rx_end),
    .rx_crc_ok   (rx_crc_ok),
    .rx_frame_err(rx_frame_err)
);

// File: tb/test_owb_xcvr.sv
module test_owb_xcvr;
    localparam int CNT_W = 18;

    // {period[31:16], first byte[15:8], second byte[7:0]}
    localparam logic [31:0] VEC [4] = '{
        32'h0010_A53C,
        32'h0028_00FF,
        32'h000C_8001,
        32'h0040_7E81
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [CNT_W-1:0] a_per = 18'd16;
    logic [7:0] a_data = 8'h00;
    logic a_last = 1'b0, a_valid = 1'b0, a_ready;
    logic [7:0] a_rdata; logic a_rvalid, a_end, a_ok, a_err, a_oe;
    logic [7:0] b_rdata; logic b_rvalid, b_end, b_ok, b_err, b_oe, b_ready;
    logic ext = 1'b0;
    logic line;
    assign line = a_oe | b_oe | ext;

    owb_xcvr #(.CNT_W(CNT_W)) i_owb_xcvr (
        .clk(clk), .rst_n(rst_n), .tx_period(a_per), .tx_data(a_data),
        .tx_last(a_last), .tx_valid(a_valid), .tx_ready(a_ready),
        .rx_data(a_rdata), .rx_valid(a_rvalid), .rx_end(a_end), .rx_crc_ok(a_ok),
        .rx_frame_err(a_err), .line_oe(a_oe), .line_in(line));

    owb_xcvr #(.CNT_W(CNT_W)) i_owb_xcvr_peer (
        .clk(clk), .rst_n(rst_n), .tx_period(18'd16), .tx_data(8'h00),
        .tx_last(1'b0), .tx_valid(1'b0), .tx_ready(b_ready),
        .rx_data(b_rdata), .rx_valid(b_rvalid), .rx_end(b_end), .rx_crc_ok(b_ok),
        .rx_frame_err(b_err), .line_oe(b_oe), .line_in(line));

    int n_chk = 0, n_err = 0;
    logic [7:0] rxb [8];
    int b_n = 0, b_ends = 0, b_errs = 0, a_evt = 0;
    logic b_last_ok = 1'b0;

    always @(negedge clk) begin
        if (b_rvalid) begin
            if (b_n < 8) rxb[b_n] = b_rdata;
            b_n = b_n + 1;
        end
        if (b_end) begin
            b_ends = b_ends + 1;
            b_last_ok = b_ok;
        end
        if (b_err) b_errs = b_errs + 1;
        if (a_rvalid || a_end || a_err) a_evt = a_evt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic send_byte(input logic [7:0] v, input logic last);
        @(negedge clk);
        while (!a_ready) @(negedge clk);
        a_data = v; a_last = last; a_valid = 1'b1;
        @(negedge clk);
        a_valid = 1'b0;
        chk("R10 ready low after accept", int'(a_ready), 0);
    endtask

    task automatic measure(output int w1, output int p1, output int w2);
        @(negedge clk);
        while (!a_oe) @(negedge clk);
        w1 = 0;
        while (a_oe) begin w1++; @(negedge clk); end
        p1 = w1;
        while (!a_oe) begin p1++; @(negedge clk); end
        w2 = 0;
        while (a_oe) begin w2++; @(negedge clk); end
    endtask

    task automatic wait_done(input int e0, input int r0, input int gap);
        int t;
        t = 0;
        while (b_ends == e0 && b_errs == r0 && t < 20000) begin
            @(posedge clk); t++;
        end
        repeat (gap) @(posedge clk);
    endtask

    task automatic pulse(input int hi, input int per);
        @(negedge clk); ext = 1'b1;
        repeat (hi - 1) @(negedge clk);
        @(negedge clk); ext = 1'b0;
        repeat (per - hi - 1) @(negedge clk);
    endtask

    task automatic raw_byte(input logic [7:0] v, input int per);
        for (int k = 7; k >= 0; k--) pulse(v[k] ? per - per / 4 : per / 4, per);
    endtask

    logic done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int w1, p1, w2, e0, r0, ev0, per;
        logic [7:0] b0, b1, cr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line_oe idle", int'(a_oe), 0);
        chk("R1 tx_ready idle", int'(a_ready), 1);
        chk("R1 rx outputs idle", int'(b_rvalid | b_end | b_err), 0);

        // table of messages, A sends to B; each new period is re-learned (R11)
        for (int i = 0; i < 4; i++) begin
            per = int'(VEC[i][31:16]); b0 = VEC[i][15:8]; b1 = VEC[i][7:0];
            cr = ref_crc(ref_crc(8'h00, b0), b1);
            b_n = 0; e0 = b_ends; r0 = b_errs; ev0 = a_evt;
            a_per = CNT_W'(per);
            fork
                begin send_byte(b0, 1'b0); send_byte(b1, 1'b1); end
                measure(w1, p1, w2);
            join
            wait_done(e0, r0, 3 * per + 10);
            chk("R2 sync period", p1, per);
            chk("R3 sync high width", w1, per - per / 4);
            chk("R3 first data bit width", w2, b0[7] ? per - per / 4 : per / 4);
            chk("R6 byte count", b_n, 3);
            chk("R4 R11 first byte", int'(rxb[0]), int'(b0));
            chk("R4 R11 second byte", int'(rxb[1]), int'(b1));
            chk("R5 check byte", int'(rxb[2]), int'(cr));
            chk("R7 clean end", b_ends - e0, 1);
            chk("R7 crc ok", int'(b_last_ok), 1);
            chk("R8 no framing error", b_errs - r0, 0);
            chk("R9 own receiver quiet", a_evt - ev0, 0);
        end

        // R2: period latched when the message starts
        b_n = 0; e0 = b_ends; r0 = b_errs;
        a_per = 18'd16;
        fork
            begin
                send_byte(8'h3C, 1'b0);
                repeat (5) @(negedge clk);
                a_per = 18'd50;
                send_byte(8'hC3, 1'b1);
            end
            measure(w1, p1, w2);
        join
        wait_done(e0, r0, 60);
        chk("R2 latched period", p1, 16);
        chk("R2 bytes intact", int'({rxb[0], rxb[1]}), int'(16'h3CC3));
        chk("R2 crc ok", int'(b_last_ok), 1);

        // R7: raw message with correct check byte
        b_n = 0; e0 = b_ends; r0 = b_errs;
        pulse(15, 20); raw_byte(8'h5A, 20); raw_byte(ref_crc(8'h00, 8'h5A), 20);
        wait_done(e0, r0, 10);
        chk("R7 raw good end", b_ends - e0, 1);
        chk("R7 raw good crc", int'(b_last_ok), 1);
        chk("R6 raw byte decoded", int'(rxb[0]), 32'h5A);

        // R7: corrupted check byte
        b_n = 0; e0 = b_ends; r0 = b_errs;
        pulse(15, 20); raw_byte(8'h5A, 20); raw_byte(8'h00, 20);
        wait_done(e0, r0, 10);
        chk("R7 bad crc end", b_ends - e0, 1);
        chk("R7 bad crc flagged", int'(b_last_ok), 0);
        chk("R6 bad crc byte count", b_n, 2);

        // R8: silence in mid-byte
        e0 = b_ends; r0 = b_errs;
        pulse(15, 20); pulse(5, 20); pulse(15, 20); pulse(5, 20);
        wait_done(e0, r0, 10);
        chk("R8 mid-byte timeout error", b_errs - r0, 1);
        chk("R8 no end on timeout", b_ends - e0, 0);

        // R8: high phase as long as the period
        e0 = b_ends; r0 = b_errs;
        pulse(15, 20); pulse(39, 40);
        wait_done(e0, r0, 60);
        chk("R8 long high error", b_errs - r0, 1);
        chk("R8 no end on long high", b_ends - e0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule